// File: doc/BRIEF.md
# Flow-to-channel hash selector

This block assigns a network flow to one of up to eight parallel channels so that every packet of a flow lands on the same channel. Each request carries two endpoint pairs, a source IPv4 address with its port and a destination IPv4 address with its port, plus a direction flag. For a received packet the source pair describes the remote end. For a sent packet the destination pair does. The block picks the remote pair and adds its six bytes as unsigned 8-bit values. It then takes the remainder of that sum divided by the channel count.

The channel count is a run-time input and does not have to be a power of two. Any count from 1 to 8 gives an exact remainder. A count of 0, or a count above the supported maximum, is handled as the maximum. The result is held in a single output register behind a valid/ready handshake. The direction flag is passed along with the result so the consumer can tell the two packet streams apart.

Top module: `flow_chan_hash`

## Requirements
- R1: The hash key is the unsigned sum of the six bytes of the selected pair: bits [31:24], [23:16], [15:8] and [7:0] of the address, and bits [15:8] and [7:0] of the port. The key ranges from 0 to 1530.
- R2: `out_chan_o` equals the key modulo the effective channel count, exactly, for every count from 1 to 8.
- R3: A `chan_count_i` value of 0, or any value above 8, is handled as a count of 8.
- R4: A channel count of 1 always gives channel 0.
- R5: When `is_rx_i` = 1 the key is built from `src_addr_i`/`src_port_i`. When `is_rx_i` = 0 it is built from `dst_addr_i`/`dst_port_i`. The pair that is not selected has no effect on the result.
- R6: A request is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. From the next cycle `out_valid_o` is high, with `out_chan_o` and `out_is_rx_o` (a copy of `is_rx_i`) belonging to that request.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `in_ready_o` is low and the outputs hold their values.
- R8: After reset `out_valid_o` is low. `in_ready_o` is high whenever `out_valid_o` is low.
- R9: A presented channel index is always below the effective count that was in force when its request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Block can accept a request |
| is_rx_i | input | 1 | 1 = received packet (use the source pair), 0 = sent packet (use the destination pair) |
| src_addr_i | input | 32 | Source IPv4 address |
| src_port_i | input | 16 | Source port |
| dst_addr_i | input | 32 | Destination IPv4 address |
| dst_port_i | input | 16 | Destination port |
| chan_count_i | input | 4 | Number of channels in use (0 or more than 8 means 8) |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| out_chan_o | output | 3 | Selected channel index |
| out_is_rx_o | output | 1 | Direction flag of the result |

## Verification
The assertions check the handshake on every cycle: the result appears one cycle after acceptance, it holds during back-pressure, ready is blocked while a result is stalled, and ready is high when the register is empty. They also check that a count of 1 gives channel 0 and that an index never reaches the count captured at acceptance. The assertions cannot show that the index is the correct remainder or that the right endpoint pair was used. Those are shown only by the bench's scoreboard, which compares each result with a key it computes itself. The scoreboard covers every count from 1 to 8, out-of-range counts, extreme byte values, and requests where the pair that is not selected changes.

// File: rtl/fch_pkg.sv
package fch_pkg;
  localparam int BYTE_W = 8;

  function automatic int sum_width(input int n_bytes);
    return $clog2(n_bytes * ((1 << BYTE_W) - 1) + 1);
  endfunction
endpackage

// File: rtl/fch_byte_sum.sv
module fch_byte_sum import fch_pkg::*; #(
  parameter int IN_W  = 48,
  parameter int SUM_W = 11
) (
  input  logic [IN_W-1:0]  data_i,
  output logic [SUM_W-1:0] sum_o
);
  localparam int NB = IN_W / BYTE_W;

  logic [SUM_W-1:0] part [NB+1];

  assign part[0] = '0;
  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign part[i+1] = part[i] + SUM_W'(data_i[i*BYTE_W +: BYTE_W]);
  end

  assign sum_o = part[NB];
endmodule

// File: rtl/fch_count_norm.sv
module fch_count_norm #(
  parameter int MAX_CH = 8,
  parameter int CNT_W  = 4
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] eff_o
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CH);

  // zero or out-of-range falls back to the full channel set
  assign eff_o = (cnt_i == '0 || cnt_i > MAX_V) ? MAX_V : cnt_i;
endmodule

// File: rtl/fch_mod_reduce.sv
module fch_mod_reduce #(
  parameter int SUM_W = 11,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic [SUM_W-1:0] sum_i,
  input  logic [CNT_W-1:0] div_i,   // must be >= 1
  output logic [IDX_W-1:0] mod_o
);
  localparam int WW = SUM_W + CNT_W;

  logic [WW-1:0] rem [SUM_W+1];

  assign rem[0] = WW'(sum_i);

  // restoring reduction: subtract div*2^k when it fits, k descending
  for (genvar k = 0; k < SUM_W; k++) begin : g_step
    localparam int SH = SUM_W - 1 - k;
    logic [WW-1:0] dv;
    assign dv       = WW'(div_i) << SH;
    assign rem[k+1] = (rem[k] >= dv) ? (rem[k] - dv) : rem[k];
  end

  assign mod_o = IDX_W'(rem[SUM_W]);
endmodule

// File: rtl/fch_out_reg.sv
module fch_out_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] d_i,
  input  logic         pop_i,
  output logic         ready_o,
  output logic         valid_o,
  output logic [W-1:0] q_o
);
  logic         valid_q;
  logic [W-1:0] data_q;

  assign ready_o = !valid_q || pop_i;
  assign valid_o = valid_q;
  assign q_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (push_i && ready_o) begin
      valid_q <= 1'b1;
      data_q  <= d_i;
    end else if (pop_i) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flow_chan_hash.sv
module flow_chan_hash import fch_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int MAX_CH = 8,
  localparam int CNT_W = $clog2(MAX_CH + 1),
  localparam int IDX_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              is_rx_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic [PORT_W-1:0] src_port_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [PORT_W-1:0] dst_port_i,
  input  logic [CNT_W-1:0]  chan_count_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [IDX_W-1:0]  out_chan_o,
  output logic              out_is_rx_o
);
  localparam int KEY_W = ADDR_W + PORT_W;
  localparam int SUM_W = sum_width(KEY_W / BYTE_W);
  localparam int RES_W = IDX_W + 1;

  logic [KEY_W-1:0] key;
  logic [SUM_W-1:0] bsum;
  logic [CNT_W-1:0] eff_cnt;
  logic [IDX_W-1:0] chan;
  logic [RES_W-1:0] res_q;

  // remote end: source for received, destination for sent
  assign key = is_rx_i ? {src_addr_i, src_port_i} : {dst_addr_i, dst_port_i};

  fch_byte_sum #(.IN_W(KEY_W), .SUM_W(SUM_W)) u_sum (
    .data_i (key),
    .sum_o  (bsum)
  );

  fch_count_norm #(.MAX_CH(MAX_CH), .CNT_W(CNT_W)) u_norm (
    .cnt_i (chan_count_i),
    .eff_o (eff_cnt)
  );

  fch_mod_reduce #(.SUM_W(SUM_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_mod (
    .sum_i (bsum),
    .div_i (eff_cnt),
    .mod_o (chan)
  );

  fch_out_reg #(.W(RES_W)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (in_valid_i),
    .d_i     ({chan, is_rx_i}),
    .pop_i   (out_ready_i),
    .ready_o (in_ready_o),
    .valid_o (out_valid_o),
    .q_o     (res_q)
  );

  assign out_chan_o  = res_q[RES_W-1:1];
  assign out_is_rx_o = res_q[0];
endmodule

// File: rtl/flow_chan_hash_chk.sv
module flow_chan_hash_chk #(
  parameter int MAX_CH = 8,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             is_rx_i,
  input logic [CNT_W-1:0] chan_count_i,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [IDX_W-1:0] out_chan_o,
  input logic             out_is_rx_o
);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_CH);

  logic             acc;
  logic [CNT_W-1:0] cnt_q;

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= MAX_V;
    else if (acc) cnt_q <= (chan_count_i == '0 || chan_count_i > MAX_V) ? MAX_V : chan_count_i;
  end

  p_accept_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> out_valid_o);

  p_dir_echo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (out_is_rx_o == $past(is_rx_i)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_chan_o) && $stable(out_is_rx_o)));

  p_stall_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  p_idle_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  p_single_chan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && chan_count_i == CNT_W'(1)) |=> (out_chan_o == '0));

  p_idx_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ({1'b0, out_chan_o} < (CNT_W+1)'(cnt_q)));
endmodule

bind flow_chan_hash flow_chan_hash_chk #(
  .MAX_CH(MAX_CH), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .is_rx_i      (is_rx_i),
  .chan_count_i (chan_count_i),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_chan_o   (out_chan_o),
  .out_is_rx_o  (out_is_rx_o)
);

// File: tb/flow_chan_hash_test.sv
`timescale 1ns/1ps
module flow_chan_hash_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        is_rx = 1'b0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic [15:0] src_port = '0, dst_port = '0;
  logic [3:0]  chan_count = 4'd8;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_chan;
  logic        out_is_rx;

  typedef struct {
    logic [2:0] chan;
    logic       rx;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   stall_mode = 1'b0;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  flow_chan_hash uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .is_rx_i(is_rx), .src_addr_i(src_addr), .src_port_i(src_port),
    .dst_addr_i(dst_addr), .dst_port_i(dst_port), .chan_count_i(chan_count),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_chan_o(out_chan), .out_is_rx_o(out_is_rx)
  );

  function automatic logic [2:0] model(input logic [31:0] a, input logic [15:0] p,
                                       input logic [3:0] c);
    int s;
    int e;
    s = a[31:24] + a[23:16] + a[15:8] + a[7:0] + p[15:8] + p[7:0];
    e = (c == 0 || c > 8) ? 8 : int'(c);
    return 3'(s % e);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // driver: present one request, wait for acceptance, record expectation
  task automatic send(input logic rx, input logic [31:0] sa, input logic [15:0] sp,
                      input logic [31:0] da, input logic [15:0] dp,
                      input logic [3:0] c, input string req);
    exp_t e;
    @(negedge clk);
    is_rx = rx; src_addr = sa; src_port = sp; dst_addr = da; dst_port = dp;
    chan_count = c; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.chan = rx ? model(sa, sp, c) : model(da, dp, c);
    e.rx   = rx;
    e.req  = req;
    exp_q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // consumer back-pressure pattern
  initial begin : ready_gen
    int k = 0;
    forever begin
      @(negedge clk);
      k++;
      out_ready = stall_mode ? ((k % 5 != 0) && (k % 7 != 3) && ((k / 16) % 4 != 2)) : 1'b1;
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    bit         held = 1'b0;
    logic [2:0] h_chan = '0;
    logic       h_rx = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_ni) begin
        if (held) begin
          check(out_valid && out_chan == h_chan && out_is_rx == h_rx, "R7 hold",
                int'(out_chan), int'(h_chan));
          held = 1'b0;
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected result", int'(out_chan), -1);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(out_chan == e.chan, e.req, int'(out_chan), int'(e.chan));
            check(out_is_rx == e.rx, "R6 dir", int'(out_is_rx), int'(e.rx));
          end
        end else if (out_valid) begin
          check(!in_ready, "R7 ready blocked", int'(in_ready), 0);
          held = 1'b1; h_chan = out_chan; h_rx = out_is_rx;
        end else begin
          check(in_ready, "R8 idle ready", int'(in_ready), 1);
        end
      end
    end
  end

  task automatic finish_test();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_test();
  end

  initial begin : stim
    logic [31:0] ka;
    logic [15:0] kp;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(!out_valid, "R8 reset valid", int'(out_valid), 0);
    check(in_ready, "R8 reset ready", int'(in_ready), 1);

    // R1: byte extremes and ordering
    send(1, 32'hFFFF_FFFF, 16'hFFFF, 32'h0, 16'h0, 4'd8, "R1 max key");    // 1530 % 8 = 2
    send(1, 32'h0102_0304, 16'h0506, 32'h0, 16'h0, 4'd8, "R1 small key");  // 21 % 8 = 5
    send(1, 32'h0, 16'h0, 32'hFFFF_FFFF, 16'hFFFF, 4'd7, "R1 zero key");
    send(1, 32'h8000_0080, 16'h8080, 32'h0, 16'h0, 4'd7, "R1 high bits");

    // R2: every count, several keys
    for (int c = 1; c <= 8; c++) begin
      for (int j = 0; j < 6; j++) begin
        ka = 32'h1F3D_5B79 * (j + 3) + 32'(c * 977);
        kp = 16'(16'hA5C3 * (j + 1) + c);
        send(1, ka, kp, ~ka, ~kp, 4'(c), "R2 modulo");
      end
    end

    // R3: out-of-range counts
    send(1, 32'hFFFF_FFFF, 16'hFFFF, 32'h0, 16'h0, 4'd0,  "R3 count zero");
    send(1, 32'h0102_0304, 16'h0506, 32'h0, 16'h0, 4'd9,  "R3 count nine");
    send(1, 32'hC0A8_0101, 16'h1F90, 32'h0, 16'h0, 4'd15, "R3 count fifteen");

    // R4: single channel
    send(1, 32'hFFFF_FFFF, 16'hFFFF, 32'h0, 16'h0, 4'd1, "R4 single max");
    send(0, 32'h0, 16'h0, 32'h0A0B_0C0D, 16'h0E0F, 4'd1, "R4 single tx");

    // R5: pair selection, the other pair varied
    send(0, 32'hFFFF_FFFF, 16'hFFFF, 32'h0102_0304, 16'h0506, 4'd8, "R5 tx uses dst");
    send(0, 32'h0000_0000, 16'h0000, 32'h0102_0304, 16'h0506, 4'd8, "R5 tx ignores src");
    send(1, 32'h0102_0304, 16'h0506, 32'hFFFF_FFFF, 16'hFFFF, 4'd6, "R5 rx uses src");
    send(1, 32'h0102_0304, 16'h0506, 32'h1234_5678, 16'h9ABC, 4'd6, "R5 rx ignores dst");

    // R6/R7: back-pressure with back-to-back traffic
    stall_mode = 1'b1;
    for (int j = 0; j < 40; j++) begin
      ka = 32'h9E37_79B9 * (j + 1);
      kp = 16'(16'h7F4A * (j + 2));
      send(j[0], ka, kp, ka ^ 32'h5A5A_5A5A, kp ^ 16'h3C3C, 4'(3 + j % 6), "R7 stalled flow");
    end
    stall_mode = 1'b0;

    repeat (200) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !out_valid) break;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results delivered", exp_q.size(), 0);
    finish_test();
  end
endmodule